// File: doc/BRIEF.md
# Multiplexed DRAM Address Sequencer

This block sits between a host that issues flat word addresses and an asynchronous page-mode DRAM module with a shared 12-pin address bus. For each host request it captures the address, splits it into row, column and bank fields according to a run-time geometry setting, and then walks the module through a row phase (row on the bus, the chosen bank's RAS lines low), a column phase (column on the bus, CAS low), a hold phase that carries the acknowledge, and a precharge phase with every strobe released. Every phase length is set by a programmable cycle count.

The module's four RAS lines are driven two at a time. Each bank owns one pair, and a mode input picks how the lines are grouped, so that the sequencer matches the module's wiring. Lines that belong to the other bank never move during an access.

A refresh timer raises a refresh request at a programmable interval. While idle, a pending refresh is served before any host request. A refresh is a RAS-only cycle: all four RAS lines go low with a refresh row on the bus. The refresh row counter walks through every row the current geometry has and then wraps.

Top module: `dram_addr_seq`

## Requirements
- R1: While reset is held and after it is released with no request, `ras_n` is 4'hF, `cas_n` is 1, `ack` is 0 and `ma` is 0.
- R2: An accepted request starts a row phase that lasts `t_row`+1 cycles. During it `ma` carries the row field with unused upper pins at 0, `cas_n` is 1 and only the selected bank's two RAS lines are low.
- R3: The row phase is followed by `t_col`+1 column cycles and then `t_hold`+1 hold cycles. During both, `cas_n` is 0 and `ma` carries the column field zero-extended. `ack` is a one-cycle pulse on the last hold cycle, so CAS is low for `t_col`+`t_hold`+2 cycles up to and including the `ack` cycle.
- R4: After `ack`, a precharge phase follows in which all RAS lines, CAS and `ma` are inactive for `t_pre`+1 cycles. A request held high through the `ack` starts its row phase after `t_pre`+2 inactive cycles.
- R5: `geo_sel` sets rows×columns: 0 is 12×12, 1 is 12×10, 2 is 11×11 and 3 is 12×11. The column field is the lowest address bits, the row field sits directly above it, the bank bit sits directly above the row field, and all higher address bits are ignored.
- R6: With `pair_sel`=0, bank 0 drives lines 0 and 2 and bank 1 drives lines 1 and 3. With `pair_sel`=1, bank 0 drives lines 0 and 1 and bank 1 drives lines 2 and 3. The other bank's lines stay high for the whole access.
- R7: A `ref_interval` of 0 disables refresh. Otherwise a refresh request is raised every `ref_interval`+1 cycles, so an idle sequencer starts refreshes exactly that far apart.
- R8: A refresh drives all four `ras_n` lines low, keeps `cas_n` high and puts the refresh row on `ma` for `t_row`+1 cycles, and is then followed by a precharge.
- R9: The first refresh after reset uses row 0. Each later refresh uses the next row, and the count wraps to 0 after 2048 rows with 11 row bits and after 4096 rows with 12 row bits.
- R10: A refresh that is pending while the sequencer is idle is served before a waiting host request. A refresh that becomes pending during an access does not disturb that access.
- R11: The address is captured when the request is accepted. Later changes on `haddr` during the access have no effect on `ma`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host access request, held until `ack` |
| haddr | input | 25 | Host word address |
| ack | output | 1 | One-cycle acknowledge in the hold phase |
| geo_sel | input | 2 | Row/column geometry select |
| pair_sel | input | 1 | RAS line pairing mode |
| t_row | input | 4 | Row phase length minus one |
| t_col | input | 4 | Column phase length minus one |
| t_hold | input | 4 | Hold phase length minus one |
| t_pre | input | 4 | Precharge length minus one |
| ref_interval | input | 16 | Refresh period minus one, 0 disables refresh |
| ma | output | 12 | Multiplexed module address |
| ras_n | output | 4 | Active-low row strobes |
| cas_n | output | 1 | Active-low column strobe |

## Verification
The bench sends addresses with the bank bit and the ignored upper bits set, under every geometry. A wrong field split would put a shifted row or column on the bus, or would select the wrong RAS pair. Both pairing modes are run with both banks. A decode that mixed up the modes would pull down lines of the idle bank. Refresh sweeps of 2048 and 4096 rows check the wrap point: a counter masked to the wrong width would wrap early or carry a stray top bit. A refresh that comes due during a long access must wait until that access is over, and must then win over a request that is already waiting. A sequencer that broke into the access would show all four RAS lines low in the middle of a column phase. One that let the host go first would show a RAS pair instead of the refresh pattern as the first active cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int unsigned MA_W = 12;
  localparam int unsigned HA_W = 2 * MA_W + 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_COL,
    PH_HOLD,
    PH_PRE,
    PH_REF
  } phase_e;

  // geometry code -> row bit count (only code 2 is short by one)
  function automatic int unsigned geo_row_bits(input logic [1:0] g);
    return (g == 2'd2) ? MA_W - 1 : MA_W;
  endfunction

  // geometry code -> column bit count
  function automatic int unsigned geo_col_bits(input logic [1:0] g);
    int unsigned n;
    case (g)
      2'd0:    n = MA_W;
      2'd1:    n = MA_W - 2;
      default: n = MA_W - 1;
    endcase
    return n;
  endfunction

  // ones in the lowest n bits of an address-pin-wide word
  function automatic logic [MA_W-1:0] field_mask(input int unsigned n);
    logic [MA_W:0] m;
    m = ((MA_W+1)'(1) << n) - (MA_W+1)'(1);
    return m[MA_W-1:0];
  endfunction

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split
  import dram_seq_pkg::*;
(
  input  logic [HA_W-1:0] haddr,
  input  logic [1:0]      geo_sel,
  output logic [MA_W-1:0] row,
  output logic [MA_W-1:0] col,
  output logic            bank
);

  int unsigned      cb;
  int unsigned      rb;
  logic [HA_W-1:0]  sh_row;
  logic [HA_W-1:0]  sh_bank;

  always_comb begin
    cb      = geo_col_bits(geo_sel);
    rb      = geo_row_bits(geo_sel);
    col     = haddr[MA_W-1:0] & field_mask(cb);
    sh_row  = haddr >> cb;
    row     = sh_row[MA_W-1:0] & field_mask(rb);
    sh_bank = haddr >> (cb + rb);
    bank    = sh_bank[0];
  end

endmodule

// File: rtl/dram_ras_decode.sv
module dram_ras_decode #(
  parameter int unsigned NRAS = 4
) (
  input  logic            acc_en,
  input  logic            ref_en,
  input  logic            bank,
  input  logic            pair_sel,
  output logic [NRAS-1:0] ras_n
);

  localparam int unsigned HALF = NRAS / 2;

  for (genvar gi = 0; gi < NRAS; gi++) begin : g_line
    // interleaved grouping: even lines bank 0, odd lines bank 1
    localparam bit OWN_IL = ((gi % 2) == 1);
    // blocked grouping: lower half bank 0, upper half bank 1
    localparam bit OWN_BL = ((gi / HALF) == 1);
    logic owner;
    assign owner     = pair_sel ? OWN_BL : OWN_IL;
    assign ras_n[gi] = ~(ref_en | (acc_en & (bank == owner)));
  end

endmodule

// File: rtl/dram_refresh_unit.sv
module dram_refresh_unit
  import dram_seq_pkg::*;
#(
  parameter int unsigned RI_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RI_W-1:0] interval,
  input  logic [1:0]      geo_sel,
  input  logic            ref_take,
  input  logic            ref_done,
  output logic            ref_pend,
  output logic [MA_W-1:0] ref_row
);

  logic [RI_W-1:0] tcnt;
  logic [MA_W-1:0] row_q;
  logic [MA_W-1:0] rmask;

  assign rmask   = field_mask(geo_row_bits(geo_sel));
  assign ref_row = row_q & rmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt     <= '0;
      ref_pend <= 1'b0;
      row_q    <= '0;
    end else begin
      if (interval == '0) begin
        tcnt     <= '0;
        ref_pend <= 1'b0;
      end else if (tcnt >= interval) begin
        tcnt     <= '0;
        ref_pend <= 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
        if (ref_take) ref_pend <= 1'b0;
      end
      if (ref_done) row_q <= (row_q + 1'b1) & rmask;
    end
  end

  // R10: a request stays pending until the sequencer takes it
  p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !ref_take && interval != '0) |=> ref_pend);

endmodule

// File: rtl/dram_phase_fsm.sv
module dram_phase_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          ref_pend,
  input  logic [TW-1:0] t_row,
  input  logic [TW-1:0] t_col,
  input  logic [TW-1:0] t_hold,
  input  logic [TW-1:0] t_pre,
  output phase_e        phase,
  output logic          ack,
  output logic          accept,
  output logic          ref_take,
  output logic          ref_done
);

  phase_e        nxt;
  logic [TW-1:0] cnt;
  logic [TW-1:0] dur;
  logic          last;

  always_comb begin
    case (phase)
      PH_ROW:  dur = t_row;
      PH_COL:  dur = t_col;
      PH_HOLD: dur = t_hold;
      PH_PRE:  dur = t_pre;
      PH_REF:  dur = t_row;
      default: dur = '0;
    endcase
    last     = (cnt == dur);
    accept   = (phase == PH_IDLE) && !ref_pend && req;
    ref_take = (phase == PH_IDLE) && ref_pend;
    ack      = (phase == PH_HOLD) && last;
    ref_done = (phase == PH_REF) && last;
    nxt      = phase;
    case (phase)
      PH_IDLE: if (ref_pend) nxt = PH_REF;
               else if (req) nxt = PH_ROW;
      PH_ROW:  if (last) nxt = PH_COL;
      PH_COL:  if (last) nxt = PH_HOLD;
      PH_HOLD: if (last) nxt = PH_PRE;
      PH_PRE:  if (last) nxt = PH_IDLE;
      PH_REF:  if (last) nxt = PH_PRE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= nxt;
      cnt   <= (nxt != phase || phase == PH_IDLE) ? '0 : cnt + 1'b1;
    end
  end

  // R3: acknowledge is a single-cycle pulse
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R10: an idle sequencer with refresh pending goes to refresh next
  p_ref_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && ref_pend) |=> (phase == PH_REF));

endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned TW   = 4,
  parameter int unsigned RI_W = 16,
  parameter int unsigned NRAS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [HA_W-1:0] haddr,
  output logic            ack,
  input  logic [1:0]      geo_sel,
  input  logic            pair_sel,
  input  logic [TW-1:0]   t_row,
  input  logic [TW-1:0]   t_col,
  input  logic [TW-1:0]   t_hold,
  input  logic [TW-1:0]   t_pre,
  input  logic [RI_W-1:0] ref_interval,
  output logic [MA_W-1:0] ma,
  output logic [NRAS-1:0] ras_n,
  output logic            cas_n
);

  phase_e          phase;
  logic            accept;
  logic            ref_take;
  logic            ref_done;
  logic            ref_pend;
  logic [MA_W-1:0] ref_row;
  logic [MA_W-1:0] sp_row;
  logic [MA_W-1:0] sp_col;
  logic            sp_bank;
  logic [MA_W-1:0] row_q;
  logic [MA_W-1:0] col_q;
  logic            bank_q;
  logic            acc_en;
  logic            ref_en;

  dram_addr_split u_split (
    .haddr   (haddr),
    .geo_sel (geo_sel),
    .row     (sp_row),
    .col     (sp_col),
    .bank    (sp_bank)
  );

  dram_phase_fsm #(.TW(TW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ref_pend (ref_pend),
    .t_row    (t_row),
    .t_col    (t_col),
    .t_hold   (t_hold),
    .t_pre    (t_pre),
    .phase    (phase),
    .ack      (ack),
    .accept   (accept),
    .ref_take (ref_take),
    .ref_done (ref_done)
  );

  dram_refresh_unit #(.RI_W(RI_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .interval (ref_interval),
    .geo_sel  (geo_sel),
    .ref_take (ref_take),
    .ref_done (ref_done),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= 1'b0;
    end else if (accept) begin
      row_q  <= sp_row;
      col_q  <= sp_col;
      bank_q <= sp_bank;
    end
  end

  assign acc_en = (phase == PH_ROW) || (phase == PH_COL) || (phase == PH_HOLD);
  assign ref_en = (phase == PH_REF);
  assign cas_n  = !((phase == PH_COL) || (phase == PH_HOLD));

  always_comb begin
    case (phase)
      PH_ROW:          ma = row_q;
      PH_COL, PH_HOLD: ma = col_q;
      PH_REF:          ma = ref_row;
      default:         ma = '0;
    endcase
  end

  dram_ras_decode #(.NRAS(NRAS)) u_ras (
    .acc_en   (acc_en),
    .ref_en   (ref_en),
    .bank     (bank_q),
    .pair_sel (pair_sel),
    .ras_n    (ras_n)
  );

  // R3: CAS only falls while some RAS line is low
  p_cas_needs_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (ras_n != '1));

  // R4: the cycle after the acknowledge releases every strobe
  p_pre_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (ras_n == '1 && cas_n));

  // R6: the active RAS pattern does not change until all lines release
  p_ras_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n != '1) |=> (ras_n == '1 || $stable(ras_n)));

  // R8: a refresh cycle never drives CAS
  p_refresh_no_cas_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0) |-> cas_n);

  // R11: the column stays put while CAS is low
  p_col_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |=> (cas_n || $stable(ma)));

endmodule

// File: tb/sim_dram_addr_seq.sv
`timescale 1ns/1ps
module sim_dram_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [24:0] haddr = '0;
  logic        ack;
  logic [1:0]  geo_sel = 2'd0;
  logic        pair_sel = 1'b0;
  logic [3:0]  tr = 4'd2, tc = 4'd1, th = 4'd1, tp = 4'd2;
  logic [15:0] ref_interval = '0;
  logic [11:0] ma;
  logic [3:0]  ras_n;
  logic        cas_n;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dram_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .haddr(haddr), .ack(ack),
    .geo_sel(geo_sel), .pair_sel(pair_sel),
    .t_row(tr), .t_col(tc), .t_hold(th), .t_pre(tp),
    .ref_interval(ref_interval), .ma(ma), .ras_n(ras_n), .cas_n(cas_n)
  );

  typedef struct packed {
    logic [1:0]  geo;
    logic        pair;
    logic [24:0] addr;
    logic [11:0] row;
    logic [11:0] col;
    logic [3:0]  ras;
  } vec_t;

  // R5/R6 vectors: geometry, pairing, address, expected row, column, ras_n
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 25'h0ABC123, 12'hABC, 12'h123, 4'hA},
    '{2'd0, 1'b0, 25'h1001FFF, 12'h001, 12'hFFF, 4'h5},
    '{2'd0, 1'b1, 25'h15550AA, 12'h555, 12'h0AA, 4'h3},
    '{2'd1, 1'b1, 25'h1A003FF, 12'h800, 12'h3FF, 4'hC},
    '{2'd2, 1'b0, 25'h17FF801, 12'h7FF, 12'h001, 4'h5},
    '{2'd3, 1'b1, 25'h17FFFFF, 12'hFFF, 12'h7FF, 4'hC},
    '{2'd3, 1'b0, 25'h0891C56, 12'h123, 12'h456, 4'h5},
    '{2'd1, 1'b0, 25'h043C155, 12'h0F0, 12'h155, 4'h5}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic [24:0] a, input logic [11:0] er, input logic [11:0] ec,
                           input logic [3:0] eras, input string tag, input bit keep,
                           input logic [24:0] nxt_a);
    int rowc = 0;
    int casc = 0;
    bit bad_r = 0;
    bit bad_c = 0;
    bit got = 0;
    logic [15:0] br = '0;
    logic [15:0] bc = '0;
    @(negedge clk);
    req = 1'b1;
    haddr = a;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (i == 0) haddr = ~a;
      if (cas_n) begin
        rowc++;
        if ((ma !== er || ras_n !== eras) && !bad_r) begin bad_r = 1; br = {ras_n, ma}; end
      end else begin
        casc++;
        if ((ma !== ec || ras_n !== eras) && !bad_c) begin bad_c = 1; bc = {ras_n, ma}; end
      end
      if (ack === 1'b1) begin
        got = 1;
        if (keep) haddr = nxt_a; else req = 1'b0;
      end
    end
    chk(!bad_r, {tag, " R2/R5/R6/R11 row phase {ras,ma}"}, 32'(br), 32'({eras, er}));
    chk(rowc == int'(tr) + 1, {tag, " R2 row cycles"}, 32'(rowc), 32'(int'(tr) + 1));
    chk(!bad_c, {tag, " R3/R5/R6/R11 column phase {ras,ma}"}, 32'(bc), 32'({eras, ec}));
    chk(got && casc == int'(tc) + int'(th) + 2, {tag, " R3 cas-low cycles to ack"},
        32'(casc), 32'(int'(tc) + int'(th) + 2));
    if (!keep) begin
      bit bad_p = 0;
      for (int i = 0; i <= int'(tp); i++) begin
        @(negedge clk);
        if (ras_n !== 4'hF || cas_n !== 1'b1 || ma !== 12'h0) bad_p = 1;
      end
      chk(!bad_p, {tag, " R4 precharge idle"}, 32'(bad_p), 0);
    end
  endtask

  task automatic gap_until_active(output int gap, output logic [3:0] fr, output logic [11:0] fm);
    gap = 0;
    fr = 4'hF;
    fm = '0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ras_n !== 4'hF) begin
        fr = ras_n;
        fm = ma;
        break;
      end
      gap++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ack === 1'b1) begin
        req = 1'b0;
        break;
      end
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic sweep(input logic [1:0] g, input int nrows, input logic [3:0] trv);
    bit prev_low = 0;
    int cnt = 0;
    int run = 0;
    int cyc = 0;
    int last_start = 0;
    bit bad_seq = 0;
    bit bad_sp = 0;
    bit bad_len = 0;
    bit bad_cas = 0;
    logic [11:0] wrap_ma = 12'hFFF;
    @(negedge clk);
    rst_n = 1'b0;
    geo_sel = g;
    tr = trv;
    tp = 4'd0;
    ref_interval = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ref_interval = 16'd8;
    for (int i = 0; i < (nrows + 1) * 9 + 60; i++) begin
      bit low;
      @(negedge clk);
      cyc++;
      low = (ras_n === 4'h0);
      if (low && cas_n !== 1'b1) bad_cas = 1;
      if (low && !prev_low) begin
        if (ma !== 12'(cnt % nrows)) bad_seq = 1;
        if (cnt > 0 && cyc - last_start != 9) bad_sp = 1;
        if (cnt == nrows) wrap_ma = ma;
        last_start = cyc;
        cnt++;
        run = 0;
      end
      if (low) run++;
      if (!low && prev_low && run != int'(trv) + 1) bad_len = 1;
      prev_low = low;
      if (cnt == nrows + 1 && !low) break;
    end
    chk(!bad_seq && cnt == nrows + 1, "R9 refresh row sequence", 32'(cnt), 32'(nrows + 1));
    chk(wrap_ma == 12'h0, "R9 refresh row wraps to zero", 32'(wrap_ma), 0);
    chk(!bad_sp, "R7 refresh spacing interval+1", 32'(bad_sp), 0);
    chk(!bad_len && !bad_cas, "R8 refresh all-low length without CAS", 32'({bad_len, bad_cas}), 0);
    ref_interval = 16'd0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int gap;
    logic [3:0] fr;
    logic [11:0] fm;
    bit quiet;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(ras_n === 4'hF && cas_n === 1'b1 && ack === 1'b0 && ma === 12'h0,
        "R1 outputs during reset", 32'({ras_n, cas_n, ack, ma}), 32'({4'hF, 1'b1, 1'b0, 12'h0}));
    rst_n = 1'b1;

    // R7: interval zero means no refresh activity
    quiet = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ras_n !== 4'hF || cas_n !== 1'b1 || ma !== 12'h0) quiet = 0;
    end
    chk(quiet, "R1/R7 idle with refresh disabled", 32'(quiet), 1);

    // table walk over geometries and pairings
    foreach (VECS[k]) begin
      @(negedge clk);
      geo_sel = VECS[k].geo;
      pair_sel = VECS[k].pair;
      do_access(VECS[k].addr, VECS[k].row, VECS[k].col, VECS[k].ras,
                $sformatf("vec%0d", k), 1'b0, '0);
    end

    // minimum phase lengths
    @(negedge clk);
    tr = 0; tc = 0; th = 0; tp = 0;
    geo_sel = 2'd0; pair_sel = 1'b1;
    do_access(25'h0ABC123, 12'hABC, 12'h123, 4'hC, "min", 1'b0, '0);

    // R4: back-to-back request waits exactly t_pre+2 inactive cycles
    @(negedge clk);
    tr = 1; tc = 2; th = 0; tp = 3;
    pair_sel = 1'b0;
    do_access(25'h0001002, 12'h001, 12'h002, 4'hA, "b2b", 1'b1, 25'h1003004);
    gap_until_active(gap, fr, fm);
    chk(gap == int'(tp) + 2, "R4 gap before held request", 32'(gap), 32'(int'(tp) + 2));
    chk(fr === 4'h5 && fm === 12'h003, "R4/R6 second access row {ras,ma}",
        32'({fr, fm}), 32'({4'h5, 12'h003}));
    drain();

    // R10: refresh due mid-access waits, then beats the waiting request
    @(negedge clk);
    tr = 3; tc = 3; th = 3; tp = 1;
    ref_interval = 16'd3;
    do_access(25'h0222333, 12'h222, 12'h333, 4'hA, "R10 busy", 1'b1, 25'h0444555);
    gap_until_active(gap, fr, fm);
    ref_interval = 16'd0;
    chk(fr === 4'h0, "R10 refresh served before waiting request", 32'(fr), 0);
    chk(gap == int'(tp) + 2, "R10 refresh start after precharge", 32'(gap), 32'(int'(tp) + 2));
    drain();

    // R9/R8/R7: full sweeps for 11 and 12 row bits
    sweep(2'd2, 2048, 4'd0);
    sweep(2'd0, 4096, 4'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule